// File: doc/BRIEF.md
# Multi-Channel Request Atomizer and Router

This block sits between a set of memory clients and four independent memory channel back-ends. Every client request (a base address and a length in bytes) is cut into fixed-size service units of 64 bytes. Units go out one at a time, in address order. Each unit is steered to a channel taken from a shared, programmable channel sequence, so a single request is spread over several channels.

Each channel has its own round-robin arbiter. The arbiter picks one client per cycle among the clients whose current unit targets that channel. A channel back-end takes a unit when its ready input is high. A client's request is accepted, with its ready pulsed, in the cycle its final unit leaves. Until then the client holds its request steady, and it stalls while the channel for its current unit is busy or taken by another client.

Each unit carries the client number, its index within the request, its byte address and a flag that marks the final unit. The back-ends use these to restore order.

Top module: `mcr_router`

## Requirements
- R1: A request of L bytes yields ceil(L/64) units, and a request of length 0 yields one unit. The last-unit flag is high on the final unit of a request and low on every other unit.
- R2: Unit k of a request carries index k and address base + 64*k.
- R3: Unit k is sent to the channel held in sequence entry (k mod (cfg_seq_last+1)). Entry i is the 2-bit field cfg_seq[2i+1:2i], and a value of n selects channel n.
- R4: Every new request starts at sequence entry 0, whatever entry the previous request reached.
- R5: cl_ready of a client is high only in the cycle its final unit is accepted. While the channel for its current unit has ch_ready low, the unit stays the same and cl_ready stays low.
- R6: A channel presents at most one unit per cycle. When several clients target it, grants rotate round-robin, starting after the client that was granted last.
- R7: Clients whose current units target different channels are served in the same cycle.
- R8: After reset no channel output is valid while no client is valid. Each arbiter then favours client 0 first.
- R9: ch_client of a channel carries the number of the client whose unit it presents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_seq | input | 2*SEQ_DEPTH | Channel sequence table, 2 bits per entry |
| cfg_seq_last | input | $clog2(SEQ_DEPTH) | Index of the last used sequence entry |
| cl_valid | input | NUM_CLIENTS | Client request valid |
| cl_addr | input | 32*NUM_CLIENTS | Client base byte address |
| cl_len | input | 12*NUM_CLIENTS | Client request length in bytes |
| cl_ready | output | NUM_CLIENTS | Request accepted (final unit sent) |
| ch_valid | output | NUM_CHANS | Unit valid toward each channel |
| ch_client | output | 2*NUM_CHANS | Client number of the unit |
| ch_idx | output | 7*NUM_CHANS | Unit index within its request |
| ch_addr | output | 32*NUM_CHANS | Unit byte address |
| ch_last | output | NUM_CHANS | Final unit of its request |
| ch_ready | input | NUM_CHANS | Channel back-end accepts a unit |

## Verification
Arbitration and the stall path can act in the same cycle. When two clients aim their current units at one channel, one of them is granted and the other must hold its unit and keep cl_ready low. In a different cycle, a single client can be held back by a channel with ch_ready low. The bench provokes the conflict by pointing every sequence entry at one channel and raising both clients together, and judges the winner against the round-robin order over three successive cycles. It also raises a cross-channel case in which one client moves on to a second channel while the other takes the first, and checks that both finish in the same cycle.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
    localparam int ADDR_W  = 32;
    localparam int LEN_W   = 12;
    localparam int UNIT_SH = 6;
    localparam int UNIT_B  = 1 << UNIT_SH;
    localparam int CID_W   = 2;
    localparam int CH_W    = 2;
    localparam int UIDX_W  = LEN_W - UNIT_SH + 1;

    typedef struct packed {
        logic [CID_W-1:0]  cid;
        logic [UIDX_W-1:0] idx;
        logic [ADDR_W-1:0] addr;
        logic              last;
    } unit_t;

    function automatic logic [UIDX_W-1:0] unit_count(input logic [LEN_W-1:0] len);
        logic [LEN_W:0] sum;
        logic [UIDX_W-1:0] n;
        sum = {1'b0, len} + (LEN_W+1)'(UNIT_B - 1);
        n = UIDX_W'(sum >> UNIT_SH);
        return (n == '0) ? UIDX_W'(1) : n;
    endfunction
endpackage

// File: rtl/mcr_atomizer.sv
module mcr_atomizer
    import mcr_pkg::*;
#(
    parameter int CLIENT_ID = 0,
    parameter int SEQ_DEPTH = 8,
    localparam int SEQ_W    = $clog2(SEQ_DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CH_W*SEQ_DEPTH-1:0] cfg_seq,
    input  logic [SEQ_W-1:0]        cfg_seq_last,
    input  logic                    in_valid,
    input  logic [ADDR_W-1:0]       in_addr,
    input  logic [LEN_W-1:0]        in_len,
    input  logic                    unit_fire,
    output unit_t                   unit,
    output logic [CH_W-1:0]         tgt,
    output logic                    in_ready
);
    logic [UIDX_W-1:0] cnt_q;
    logic [SEQ_W-1:0]  ptr_q;
    logic [UIDX_W-1:0] total;

    always_comb begin
        total     = unit_count(in_len);
        unit.cid  = CID_W'(CLIENT_ID);
        unit.idx  = cnt_q;
        unit.addr = in_addr + (ADDR_W'(cnt_q) << UNIT_SH);
        unit.last = (cnt_q == total - UIDX_W'(1));
        tgt       = cfg_seq[ptr_q*CH_W +: CH_W];
        in_ready  = unit_fire && unit.last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ptr_q <= '0;
        end else if (unit_fire) begin
            if (unit.last) begin
                cnt_q <= '0;
                ptr_q <= '0;
            end else begin
                cnt_q <= cnt_q + UIDX_W'(1);
                ptr_q <= (ptr_q == cfg_seq_last) ? '0 : ptr_q + SEQ_W'(1);
            end
        end
    end

    // R2: a non-final unit is followed by one 64 bytes further on
    p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && unit_fire && !unit.last) |=>
            (!in_valid || in_addr != $past(in_addr) ||
             unit.addr == $past(unit.addr) + ADDR_W'(UNIT_B)));

    // R5: request acceptance only with the final unit
    p_ready_last_r5: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (unit.last && in_valid));
endmodule

// File: rtl/mcr_rr_arbiter.sv
module mcr_rr_arbiter
    import mcr_pkg::*;
#(
    parameter int NUM_CLIENTS = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_CLIENTS-1:0] req,
    input  logic                   ready,
    output logic [NUM_CLIENTS-1:0] gnt
);
    logic [CID_W-1:0] last_q;
    logic [CID_W-1:0] win;
    logic             found;

    always_comb begin
        gnt   = '0;
        win   = last_q;
        found = 1'b0;
        for (int i = 1; i <= NUM_CLIENTS; i++) begin
            int idx;
            idx = int'(last_q) + i;
            if (idx >= NUM_CLIENTS) idx = idx - NUM_CLIENTS;
            if (!found && req[idx]) begin
                found    = 1'b1;
                gnt[idx] = 1'b1;
                win      = CID_W'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= CID_W'(NUM_CLIENTS - 1);
        else if (found && ready) last_q <= win;
    end

    // R6: one client per channel per cycle
    p_onehot_grant_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R6: a grant only goes to a requester
    p_grant_req_r6: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);
endmodule

// File: rtl/mcr_router.sv
module mcr_router
    import mcr_pkg::*;
#(
    parameter int NUM_CLIENTS = 2,
    parameter int NUM_CHANS   = 4,
    parameter int SEQ_DEPTH   = 8,
    localparam int SEQ_W      = $clog2(SEQ_DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [CH_W*SEQ_DEPTH-1:0]     cfg_seq,
    input  logic [SEQ_W-1:0]              cfg_seq_last,
    input  logic [NUM_CLIENTS-1:0]        cl_valid,
    input  logic [ADDR_W*NUM_CLIENTS-1:0] cl_addr,
    input  logic [LEN_W*NUM_CLIENTS-1:0]  cl_len,
    output logic [NUM_CLIENTS-1:0]        cl_ready,
    output logic [NUM_CHANS-1:0]          ch_valid,
    output logic [CID_W*NUM_CHANS-1:0]    ch_client,
    output logic [UIDX_W*NUM_CHANS-1:0]   ch_idx,
    output logic [ADDR_W*NUM_CHANS-1:0]   ch_addr,
    output logic [NUM_CHANS-1:0]          ch_last,
    input  logic [NUM_CHANS-1:0]          ch_ready
);
    unit_t                              units [NUM_CLIENTS];
    logic [CH_W-1:0]                    tgt   [NUM_CLIENTS];
    logic [NUM_CLIENTS-1:0]             fire;
    logic [NUM_CHANS-1:0][NUM_CLIENTS-1:0] req;
    logic [NUM_CHANS-1:0][NUM_CLIENTS-1:0] gnt;

    for (genvar c = 0; c < NUM_CLIENTS; c++) begin : g_cl
        mcr_atomizer #(.CLIENT_ID(c), .SEQ_DEPTH(SEQ_DEPTH)) u_atom (
            .clk          (clk),
            .rst          (rst),
            .cfg_seq      (cfg_seq),
            .cfg_seq_last (cfg_seq_last),
            .in_valid     (cl_valid[c]),
            .in_addr      (cl_addr[c*ADDR_W +: ADDR_W]),
            .in_len       (cl_len[c*LEN_W +: LEN_W]),
            .unit_fire    (fire[c]),
            .unit         (units[c]),
            .tgt          (tgt[c]),
            .in_ready     (cl_ready[c])
        );

        // R5: a client aimed at a busy channel is never accepted
        p_stall_r5: assert property (@(posedge clk) disable iff (rst)
            (cl_valid[c] && !ch_ready[tgt[c]]) |-> !cl_ready[c]);
    end

    always_comb begin
        for (int k = 0; k < NUM_CHANS; k++)
            for (int c = 0; c < NUM_CLIENTS; c++)
                req[k][c] = cl_valid[c] && (int'(tgt[c]) == k);
        for (int c = 0; c < NUM_CLIENTS; c++)
            fire[c] = gnt[tgt[c]][c] && ch_ready[tgt[c]];
    end

    for (genvar k = 0; k < NUM_CHANS; k++) begin : g_ch
        mcr_rr_arbiter #(.NUM_CLIENTS(NUM_CLIENTS)) u_arb (
            .clk   (clk),
            .rst   (rst),
            .req   (req[k]),
            .ready (ch_ready[k]),
            .gnt   (gnt[k])
        );
    end

    always_comb begin
        ch_valid  = '0;
        ch_client = '0;
        ch_idx    = '0;
        ch_addr   = '0;
        ch_last   = '0;
        for (int k = 0; k < NUM_CHANS; k++) begin
            ch_valid[k] = |gnt[k];
            for (int c = 0; c < NUM_CLIENTS; c++) begin
                if (gnt[k][c]) begin
                    ch_client[k*CID_W +: CID_W]   = units[c].cid;
                    ch_idx[k*UIDX_W +: UIDX_W]    = units[c].idx;
                    ch_addr[k*ADDR_W +: ADDR_W]   = units[c].addr;
                    ch_last[k]                    = units[c].last;
                end
            end
        end
    end

    // R8: no unit without a requesting client
    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (cl_valid == '0) |-> (ch_valid == '0));
endmodule

// File: tb/sim_mcr_router.sv
module sim_mcr_router;
    localparam int NC = 2, NCH = 4, SD = 8;

    logic          clk = 0, rst = 1;
    logic [2*SD-1:0] cfg_seq = '0;
    logic [2:0]    cfg_seq_last = '0;
    logic [NC-1:0] cl_valid = '0;
    logic [32*NC-1:0] cl_addr = '0;
    logic [12*NC-1:0] cl_len = '0;
    logic [NC-1:0] cl_ready;
    logic [NCH-1:0] ch_valid, ch_last;
    logic [NCH-1:0] ch_ready = '1;
    logic [2*NCH-1:0] ch_client;
    logic [7*NCH-1:0] ch_idx;
    logic [32*NCH-1:0] ch_addr;

    int checks = 0, errors = 0;
    bit done = 0;

    mcr_router #(.NUM_CLIENTS(NC), .NUM_CHANS(NCH), .SEQ_DEPTH(SD)) u0 (
        .clk(clk), .rst(rst), .cfg_seq(cfg_seq), .cfg_seq_last(cfg_seq_last),
        .cl_valid(cl_valid), .cl_addr(cl_addr), .cl_len(cl_len), .cl_ready(cl_ready),
        .ch_valid(ch_valid), .ch_client(ch_client), .ch_idx(ch_idx),
        .ch_addr(ch_addr), .ch_last(ch_last), .ch_ready(ch_ready));

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1; cl_valid = '0; ch_ready = '1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
    endtask

    task automatic check_unit(input int ch, input int c, input int k,
                              input longint base, input bit last);
        chk(ch_valid[ch] == 1'b1, "R3 unit on expected channel", ch_valid, 1 << ch);
        chk(ch_client[ch*2 +: 2] == c, "R9 client id", ch_client[ch*2 +: 2], c);
        chk(ch_idx[ch*7 +: 7] == k, "R2 unit index", ch_idx[ch*7 +: 7], k);
        chk(ch_addr[ch*32 +: 32] == 32'(base + 64*k), "R2 unit address",
            ch_addr[ch*32 +: 32], base + 64*k);
        chk(ch_last[ch] == last, "R1 last flag", ch_last[ch], last);
    endtask

    // single client, all channels ready
    task automatic run_single(input int c, input longint base, input int len,
                              input logic [2*SD-1:0] tbl, input int sl);
        int n;
        n = (len == 0) ? 1 : (len + 63) / 64;
        cfg_seq = tbl; cfg_seq_last = 3'(sl); ch_ready = '1;
        for (int k = 0; k < n; k++) begin
            int ch;
            @(negedge clk);
            if (k == 0) begin
                cl_addr[c*32 +: 32] = 32'(base);
                cl_len[c*12 +: 12]  = 12'(len);
                cl_valid = '0; cl_valid[c] = 1'b1;
            end
            #1;
            ch = int'(tbl[(k % (sl + 1))*2 +: 2]);
            chk(ch_valid == 4'(1 << ch), "R3 only target channel valid", ch_valid, 1 << ch);
            check_unit(ch, c, k, base, k == n - 1);
            chk(cl_ready == 2'((k == n - 1) << c), "R5 ready with final unit only",
                cl_ready, (k == n - 1) << c);
        end
        @(negedge clk); cl_valid = '0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk(ch_valid == '0, "R8 no valid after reset", ch_valid, 0);
        chk(cl_ready == '0, "R8 no ready after reset", cl_ready, 0);
    endtask

    task automatic t_lengths();
        // R1: rounding up, zero length, exact multiple
        run_single(0, 64'h1000, 200, 16'h00E4, 3);
        run_single(1, 64'h8000, 0,   16'h00E4, 3);
        run_single(0, 64'h2000, 64,  16'h00E4, 3);
        run_single(1, 64'h3000, 65,  16'h00E4, 3);
    endtask

    task automatic t_sequence();
        // R3: table 3,1,0 with three entries; R4: next request restarts at entry 0
        run_single(0, 64'h4000, 320, 16'h0007, 2);
        run_single(0, 64'h5000, 128, 16'h0007, 2);
    endtask

    task automatic t_stall();
        cfg_seq = 16'h00E4; cfg_seq_last = 3'd3;
        @(negedge clk);
        ch_ready = 4'b1110;
        cl_addr[31:0] = 32'h6000; cl_len[11:0] = 12'd128; cl_valid = 2'b01;
        for (int i = 0; i < 3; i++) begin
            #1;
            check_unit(0, 0, 0, 64'h6000, 1'b0);
            chk(cl_ready == '0, "R5 no ready while stalled", cl_ready, 0);
            @(negedge clk);
        end
        ch_ready = '1;
        #1;
        check_unit(0, 0, 0, 64'h6000, 1'b0);
        @(negedge clk); #1;
        check_unit(1, 0, 1, 64'h6000, 1'b1);
        chk(cl_ready == 2'b01, "R5 ready after stall clears", cl_ready, 1);
        @(negedge clk); cl_valid = '0;
    endtask

    task automatic t_conflict();
        do_reset();
        cfg_seq = 16'h0002; cfg_seq_last = 3'd0;
        cl_addr = {32'hB000, 32'hA000}; cl_len = {12'd64, 12'd64};
        cl_valid = 2'b11; #1;
        chk(ch_valid == 4'b0100, "R6 single unit on shared channel", ch_valid, 4);
        chk(ch_client[5:4] == 2'd0, "R8 client 0 first after reset", ch_client[5:4], 0);
        chk(cl_ready == 2'b01, "R6 loser stalls", cl_ready, 1);
        @(negedge clk); #1;
        chk(ch_client[5:4] == 2'd1, "R6 rotate to client 1", ch_client[5:4], 1);
        chk(cl_ready == 2'b10, "R6 client 1 accepted", cl_ready, 2);
        @(negedge clk); #1;
        chk(ch_client[5:4] == 2'd0, "R6 rotate back to client 0", ch_client[5:4], 0);
        @(negedge clk); cl_valid = '0;
    endtask

    task automatic t_parallel();
        do_reset();
        cfg_seq = 16'h0004; cfg_seq_last = 3'd1;
        cl_addr = {32'h2000, 32'h1000}; cl_len = {12'd64, 12'd128};
        cl_valid = 2'b11; #1;
        chk(ch_valid == 4'b0001, "R7 first cycle one channel", ch_valid, 1);
        check_unit(0, 0, 0, 64'h1000, 1'b0);
        chk(cl_ready == 2'b00, "R7 none done yet", cl_ready, 0);
        @(negedge clk); #1;
        chk(ch_valid == 4'b0011, "R7 two channels in one cycle", ch_valid, 3);
        check_unit(0, 1, 0, 64'h2000, 1'b1);
        check_unit(1, 0, 1, 64'h1000, 1'b1);
        chk(cl_ready == 2'b11, "R7 both accepted together", cl_ready, 3);
        @(negedge clk); cl_valid = '0; #1;
        chk(ch_valid == '0, "R8 idle when no client valid", ch_valid, 0);
    endtask

    initial begin
        t_reset();
        t_lengths();
        t_sequence();
        t_stall();
        t_conflict();
        t_parallel();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule